// File: doc/BRIEF.md
# One-Entry Elastic Buffer with All Paths Registered

This block is a single-entry elastic stage for a valid/ready dataflow channel. A token taken from the upstream side is stored in one slot and presented downstream from registers on the next cycle. The upstream ready is also driven from a flop, so the stage breaks every combinational path: forward data, forward valid and backward ready. It is meant as a timing cut that can be dropped onto any channel.

Because the upstream ready comes from a flop, the slot can accept a token only after it has been seen empty for a full cycle. A stream that runs without stalls therefore moves at one token every two cycles. To get more capacity, place several copies back to back outside this block. The capacity parameter exists only so that a wrong value can be rejected. Any value other than one stops elaboration.

Top module: `single_slot_full_reg`

## Requirements
- R1: After reset the slot is empty: `outValid` is 0 and `inReady` is 1.
- R2: A token moves on the upstream side only in a cycle where `inValid` and `inReady` are both 1. It moves on the downstream side only in a cycle where `outValid` and `outReady` are both 1.
- R3: After an upstream transfer, `outData` equals the accepted value from the next cycle on. It stays unchanged for as long as the token is held.
- R4: `outValid` is driven from a register. It rises in the cycle after an upstream transfer and falls in the cycle after a downstream transfer.
- R5: `inReady` is driven from a flop. It falls in the cycle after an upstream transfer and rises in the cycle after a downstream transfer. A change on `outReady` never alters `inReady` within the same cycle.
- R6: The slot holds at most one token: `inReady` is 0 in every cycle where `outValid` is 1.
- R7: Tokens leave in the order they entered, with no loss and no duplication, under any pattern of `inValid` and `outReady`.
- R8: With `inValid` and `outReady` held at 1, exactly one token is accepted every two cycles.
- R9: Changes on `inData` in cycles without an upstream transfer have no effect on `outData`.
- R10: Elaboration fails when the `SLOT_COUNT` parameter differs from 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | DATA_W | Upstream token payload |
| inValid | input | 1 | Upstream offers a token |
| inReady | output | 1 | Slot can take a token (registered) |
| outData | output | DATA_W | Stored token payload (registered) |
| outValid | output | 1 | Slot holds a token (registered) |
| outReady | input | 1 | Downstream takes the stored token |

## Verification
The hardest case to produce from the ports is a change on `outReady` while the slot is full. The bench has to show that `inReady` ignores this change within the same cycle and only follows the drain one edge later. The bench drives such a pulse, probes `inReady` before the next edge, and then checks it after the edge. Random runs keep the slot alternating between held and drained under changing payloads. A behavioural queue model catches any loss, duplication or reordering.

// File: rtl/slot_buf_pkg.sv
package slot_buf_pkg;

  // Strobes sent from the control half to the storage half.
  typedef struct packed {
    logic capture;  // store the upstream payload this cycle
    logic drain;    // stored token leaves this cycle
  } slot_strobe_t;

endpackage

// File: rtl/slot_buf_ctrl.sv
module slot_buf_ctrl
  import slot_buf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output slot_strobe_t strb
);

  logic fullQ;
  logic readyQ;
  logic fullNext;
  logic readyNext;

  always_comb begin
    strb.capture = inValid && readyQ;
    strb.drain   = fullQ && outReady;
    if (fullQ) begin
      fullNext = !strb.drain;
    end else begin
      fullNext = strb.capture;
    end
    // Ready next cycle exactly when the slot will be empty next cycle.
    readyNext = (!fullQ && !strb.capture) || strb.drain;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ  <= 1'b0;
      readyQ <= 1'b1;
    end else begin
      fullQ  <= fullNext;
      readyQ <= readyNext;
    end
  end

  assign outValid = fullQ;
  assign inReady  = readyQ;

endmodule

// File: rtl/slot_buf_data.sv
module slot_buf_data
  import slot_buf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  slot_strobe_t      strb,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] slotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (strb.capture) begin
      slotQ <= inData;
    end
  end

  assign outData = slotQ;

endmodule

// File: rtl/single_slot_full_reg.sv
module single_slot_full_reg
  import slot_buf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_COUNT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  // R10: capacity is fixed; chain instances for more room.
  if (SLOT_COUNT != 1) begin : g_badSlotCount
    $error("single_slot_full_reg: SLOT_COUNT must be 1");
  end

  slot_strobe_t strb;

  slot_buf_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  slot_buf_data #(.DATA_W(DATA_W)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strb    (strb),
    .outData (outData)
  );

endmodule

// File: rtl/slot_buf_checker.sv
module slot_buf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] inData,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outReady
);

  assert_single_token_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_valid_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);

  assert_data_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outData == $past(inData)));

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_ready_return_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> inReady);

  assert_no_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && inReady) |=> (!outValid && $stable(outData)));

endmodule

bind single_slot_full_reg slot_buf_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inData   (inData),
  .inValid  (inValid),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady)
);

// File: tb/single_slot_full_reg_tb_top.sv
module single_slot_full_reg_tb_top;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic [DATA_W-1:0] inData;
  logic              inValid;
  logic              inReady;
  logic [DATA_W-1:0] outData;
  logic              outValid;
  logic              outReady;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Reference model state
  bit                modelFull;
  logic [DATA_W-1:0] modelData;
  logic [DATA_W-1:0] pendQ[$];
  int                accCount;
  int                sentCount;
  int                gotCount;

  always #2 clk = ~clk;

  single_slot_full_reg #(.DATA_W(DATA_W), .SLOT_COUNT(1)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .inReady  (inReady),
    .outData  (outData),
    .outValid (outValid),
    .outReady (outReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare ports with the model (called away from the clock edge).
  task automatic compare();
    chk(outValid == modelFull, "R4 outValid", outValid, modelFull);
    chk(inReady == !modelFull, "R5/R6 inReady", inReady, !modelFull);
    if (modelFull) chk(outData == modelData, "R3 outData", outData, modelData);
  endtask

  // One clock: inputs already driven; update model; compare after edge.
  task automatic step();
    bit acc;
    bit drn;
    acc = inValid && !modelFull;
    drn = modelFull && outReady;
    if (drn) begin
      logic [DATA_W-1:0] exp;
      exp = pendQ.pop_front();
      chk(outData == exp, "R7 order", outData, exp);
      gotCount++;
    end
    if (acc) begin
      pendQ.push_back(inData);
      sentCount++;
      accCount++;
    end
    @(posedge clk);
    if (modelFull) modelFull = !drn;
    else           modelFull = acc;
    if (acc) modelData = inData;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inData = '0; inValid = 1'b0; outReady = 1'b0;
    modelFull = 0; modelData = '0; accCount = 0; sentCount = 0; gotCount = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);

    // R2: no valid -> no transfer
    inData = 8'h5A;
    step(); step();
    chk(outValid == 1'b0, "R2 idle", outValid, 0);

    // Single token, held with outReady low; R9 payload churn ignored
    inValid = 1'b1; inData = 8'hA3;
    step();
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inData = 8'(8'h10 + i);
      step();
      chk(outData == 8'hA3, "R9 held payload", outData, 8'hA3);
    end
    inValid = 1'b0;

    // R5: pulse outReady while full; inReady must not follow in the same cycle
    outReady = 1'b1;
    #1;
    chk(inReady == 1'b0, "R5 no comb ready", inReady, 0);
    step();
    chk(inReady == 1'b1, "R5 ready after drain", inReady, 1);
    outReady = 1'b0;
    step();

    // R8: streaming throughput
    accCount = 0;
    inValid = 1'b1; outReady = 1'b1;
    for (int i = 0; i < 20; i++) begin
      inData = 8'(8'hC0 + i);
      step();
    end
    chk(accCount == 10, "R8 throughput", accCount, 10);
    inValid = 1'b0;
    step(); step();

    // R7: random valid/ready patterns
    for (int i = 0; i < 3000; i++) begin
      inValid  = ($urandom_range(0, 99) < 60);
      outReady = ($urandom_range(0, 99) < 55);
      inData   = 8'($urandom);
      step();
    end
    inValid = 1'b0; outReady = 1'b1;
    step(); step(); step();
    chk(sentCount == gotCount, "R7 no loss/dup", gotCount, sentCount);
    chk(pendQ.size() == 0, "R7 drained", pendQ.size(), 0);

    // R1: reset mid-token
    inValid = 1'b1; outReady = 1'b0; inData = 8'h77;
    step();
    rstN = 1'b0; inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelFull = 0; pendQ.delete();
    chk(outValid == 1'b0, "R1 reset empties", outValid, 0);
    chk(inReady == 1'b1, "R1 reset ready", inReady, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule